// File: doc/BRIEF.md
# Per-Token Absmax Int8 Activation Quantizer

This block turns one token's activation vector into signed 8-bit integers. The vector arrives as a stream of signed 16-bit fixed-point samples, and a last flag closes the token. While the samples come in, the block stores them and tracks the largest magnitude it has seen. Once the token is closed, it replays the stored samples. It scales each one so that the peak maps to full int8 range.

Each int8 result leaves on an output stream together with the token's peak magnitude. A later integer accumulator can then restore real units with one multiply per output element. Both sides use valid/ready handshakes. Only one token is held at a time, so new input is refused until the previous token has fully drained.

Top module: `aq_quant_top`

## Requirements
- R1: After synchronous reset `in_ready` is 1 and `out_valid` is 0.
- R2: `out_scale` carries the token's peak magnitude, the largest |x| over the token's samples, as a 16-bit unsigned value. It is present on every output beat of that token.
- R3: For a token with peak a > 0, a sample x gives q = sign(x) * floor((254*|x| + a) / (2*a)). This is x*127/a rounded half away from zero.
- R4: Every output lies in -127..+127, so the code -128 is never produced. A sample whose magnitude equals the peak maps to +127 or -127.
- R5: A token whose samples are all zero gives 0 for every element and a scale of 0.
- R6: The sample -32768 has magnitude 32768. A token containing it reports scale 32768, and that element maps to -127.
- R7: `in_ready` goes low in the cycle after a token's closing sample is accepted. It stays low until the token's final output beat is accepted, and is 1 again in the following cycle.
- R8: Outputs appear in input order, one per accepted sample. `out_last` is 1 only on the final element of each token.
- R9: A token closes when a sample with `in_last` = 1 is accepted, or when its 64th sample is accepted, whichever comes first.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_scale` and `out_last` hold their values.
- R11: The scale is computed from the current token alone. A token with a small peak that follows a token with a large peak reports its own peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed fixed-point activation sample |
| in_last | input | 1 | Marks the closing sample of a token |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer accepts the element |
| out_data | output | 8 | Signed quantized element |
| out_scale | output | 16 | Token peak magnitude (unsigned) |
| out_last | output | 1 | Marks the final element of a token |

## Verification
The assertions assume that the consumer follows the handshake: an output beat is taken only on a cycle where both valid and ready are high. They also assume that `in_data` is only meaningful on cycles where it is accepted. The bench respects both. It changes inputs only between clock edges, and it drops `in_valid` after every accepted sample, so a sample is never presented twice by accident. The bench also stalls `out_ready` on a fixed cycle pattern. This exercises the hold property against real back-pressure rather than an always-ready consumer.

// File: rtl/aq_pkg.sv
package aq_pkg;

    localparam int AQ_IN_W  = 16;
    localparam int AQ_OUT_W = 8;
    localparam int AQ_DEPTH = 64;

    // Control sequence: fill the buffer, then fetch / divide / send per element
    typedef enum logic [1:0] {
        ST_FILL,
        ST_FETCH,
        ST_DIV,
        ST_SEND
    } aq_state_e;

    // Limit a quotient to the symmetric range and apply the sign
    function automatic int signed_clamp(input int mag, input logic neg, input int qmax);
        int m;
        m = (mag > qmax) ? qmax : mag;
        return neg ? -m : m;
    endfunction

endpackage

// File: rtl/aq_peak.sv
module aq_peak #(
    parameter int IN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd,
    input  logic                   first,
    input  logic signed [IN_W-1:0] din,
    output logic        [IN_W-1:0] mag,
    output logic                   neg,
    output logic        [IN_W-1:0] peak
);

    // Two's complement negate in IN_W unsigned bits: the most negative value
    // yields 2^(IN_W-1), which is exactly its magnitude.
    always_comb begin
        neg = din[IN_W-1];
        mag = neg ? (~din + 1'b1) : din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            peak <= '0;
        end else if (upd) begin
            if (first || (mag > peak)) begin
                peak <= mag;
            end
        end
    end

    // R2: after an update the running peak covers the sample just seen
    a_r2_peak_covers: assert property (@(posedge clk) disable iff (rst)
        upd |=> (peak >= $past(mag)));

endmodule

// File: rtl/aq_buffer.sv
module aq_buffer #(
    parameter int W     = 17,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/aq_divider.sv
module aq_divider #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 17,
    parameter int Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);

    localparam int CW = $clog2(Q_W + 1);

    logic [NUM_W-1:0] rem;
    logic [NUM_W:0]   dsh;
    logic [DEN_W-1:0] den_r;
    logic [CW-1:0]    cnt;
    logic             busy;
    logic             ge;

    // Restoring division, one quotient bit per cycle, MSB first
    assign ge = ({1'b0, rem} >= dsh);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            dsh   <= '0;
            den_r <= '0;
            cnt   <= '0;
            quo   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            rem   <= num;
            dsh   <= (NUM_W+1)'(den) << (Q_W - 1);
            den_r <= den;
            quo   <= '0;
            cnt   <= CW'(Q_W);
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            if (ge) begin
                rem <= rem - dsh[NUM_W-1:0];
            end
            quo <= {quo[Q_W-2:0], ge};
            dsh <= dsh >> 1;
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R3: a finished division leaves a remainder below the divisor
    a_r3_rem_below_den: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem < NUM_W'(den_r)));

endmodule

// File: rtl/aq_quant_top.sv
module aq_quant_top
    import aq_pkg::*;
#(
    parameter int IN_W  = AQ_IN_W,
    parameter int OUT_W = AQ_OUT_W,
    parameter int DEPTH = AQ_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_data,
    output logic        [IN_W-1:0]  out_scale,
    output logic                    out_last
);

    localparam int AW    = $clog2(DEPTH);
    localparam int QMAX  = (1 << (OUT_W - 1)) - 1;
    localparam int NUM_W = IN_W + OUT_W;
    localparam int DEN_W = IN_W + 1;
    localparam int EW    = IN_W + 1;

    typedef struct packed {
        logic            neg;
        logic [IN_W-1:0] mag;
    } entry_t;

    aq_state_e state;
    logic [AW-1:0] wcnt, rcnt, last_idx;
    logic                    cur_neg;
    logic signed [OUT_W-1:0] out_q;

    logic            accept;
    logic [IN_W-1:0] in_mag, peak;
    logic            in_neg;
    entry_t          wr_entry, rd_entry;
    logic [EW-1:0]   rd_bits;

    logic             div_start, div_done;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;
    logic [OUT_W-1:0] div_quo;

    assign in_ready = (state == ST_FILL);
    assign accept   = in_valid && in_ready;

    aq_peak #(.IN_W(IN_W)) u_peak (
        .clk   (clk),
        .rst   (rst),
        .upd   (accept),
        .first (wcnt == '0),
        .din   (in_data),
        .mag   (in_mag),
        .neg   (in_neg),
        .peak  (peak)
    );

    always_comb begin
        wr_entry.neg = in_neg;
        wr_entry.mag = in_mag;
    end

    aq_buffer #(.W(EW), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (accept),
        .waddr (wcnt),
        .wdata (wr_entry),
        .raddr (rcnt),
        .rdata (rd_bits)
    );

    assign rd_entry = entry_t'(rd_bits);

    // Rounded ratio: floor((2*QMAX*|x| + a) / (2*a))
    assign div_start = (state == ST_FETCH) && (peak != '0);
    assign div_num   = NUM_W'(rd_entry.mag) * NUM_W'(2 * QMAX) + NUM_W'(peak);
    assign div_den   = {peak, 1'b0};

    aq_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(OUT_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            wcnt     <= '0;
            rcnt     <= '0;
            last_idx <= '0;
            cur_neg  <= 1'b0;
            out_q    <= '0;
        end else begin
            case (state)
                ST_FILL: begin
                    if (accept) begin
                        if (in_last || (wcnt == AW'(DEPTH - 1))) begin
                            last_idx <= wcnt;
                            rcnt     <= '0;
                            state    <= ST_FETCH;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    cur_neg <= rd_entry.neg;
                    if (peak == '0) begin
                        out_q <= '0;
                        state <= ST_SEND;
                    end else begin
                        state <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        out_q <= OUT_W'(signed_clamp(int'(div_quo), cur_neg, QMAX));
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        if (rcnt == last_idx) begin
                            wcnt  <= '0;
                            state <= ST_FILL;
                        end else begin
                            rcnt  <= rcnt + 1'b1;
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_FILL;
            endcase
        end
    end

    assign out_valid = (state == ST_SEND);
    assign out_data  = out_q;
    assign out_scale = peak;
    assign out_last  = (state == ST_SEND) && (rcnt == last_idx);

    // R7: no input is taken while an output element is pending
    a_r7_no_input_while_draining: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R10: a stalled output beat holds steady
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_scale) && $stable(out_last)));

    // R4: the asymmetric code is never emitted
    a_r4_no_min_code: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data != {1'b1, {(OUT_W-1){1'b0}}}));

    // R5: a zero scale goes with zero data
    a_r5_zero_scale_zero_data: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_scale == '0)) |-> (out_data == '0));

endmodule

// File: tb/tb_aq_quant_top.sv
`timescale 1ns/1ps
module tb_aq_quant_top;

    localparam int NV = 22;
    // Each entry: {last, sample}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 16'sd100}, {1'b0, -16'sd50}, {1'b0, 16'sd25}, {1'b1, 16'sd0},
        {1'b0, 16'sd0}, {1'b0, 16'sd0}, {1'b1, 16'sd0},
        {1'b0, 16'h8000}, {1'b0, 16'sd16384}, {1'b0, 16'sd1}, {1'b0, -16'sd1}, {1'b1, 16'sd32767},
        {1'b1, 16'sd3},
        {1'b0, 16'sd7}, {1'b0, -16'sd7}, {1'b0, 16'sd3}, {1'b0, -16'sd3}, {1'b0, 16'sd1}, {1'b1, -16'sd2},
        {1'b0, 16'sd1000}, {1'b0, -16'sd999}, {1'b1, 16'sd500}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, in_last;
    logic signed [15:0] in_data;
    logic out_valid, out_ready, out_last;
    logic signed [7:0] out_data;
    logic [15:0] out_scale;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 1'b0;

    logic signed [15:0] tok [64];
    int tlen = 0;
    int prev_scale = -1;

    logic signed [7:0] exp_d [$];
    logic [15:0]       exp_s [$];
    logic              exp_l [$];
    string             exp_t [$];
    string             exp_st [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aq_quant_top dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_scale(out_scale), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Build expected beats for the token just closed
    task automatic close_token();
        int a, m, q;
        string stag, t;
        a = 0;
        for (int i = 0; i < tlen; i++) begin
            m = (int'(tok[i]) < 0) ? -int'(tok[i]) : int'(tok[i]);
            if (m > a) a = m;
        end
        stag = (prev_scale > a) ? "R11" : "R2";
        prev_scale = a;
        for (int i = 0; i < tlen; i++) begin
            m = (int'(tok[i]) < 0) ? -int'(tok[i]) : int'(tok[i]);
            if (a == 0) begin
                q = 0; t = "R5";
            end else begin
                q = (254 * m + a) / (2 * a);
                if (q > 127) q = 127;
                if (int'(tok[i]) < 0) q = -q;
                if (int'(tok[i]) == -32768) t = "R6";
                else if (m == a) t = "R4";
                else t = "R3";
            end
            exp_d.push_back(8'(q));
            exp_s.push_back(16'(a));
            exp_l.push_back(i == tlen - 1);
            exp_t.push_back(t);
            exp_st.push_back(stag);
        end
        tlen = 0;
    endtask

    task automatic send(input logic signed [15:0] d, input logic l);
        bit closing;
        string ctag;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        tok[tlen] = d;
        tlen++;
        closing = l || (tlen == 64);
        ctag = l ? "R7" : "R9";
        if (closing) close_token();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (closing) check(in_ready === 1'b0, ctag, "in_ready after token close", int'(in_ready), 0);
    endtask

    // Output monitor with a stalling consumer
    initial begin
        bit want_ready = 1'b0;
        bit stalled = 1'b0;
        logic signed [7:0] sd;
        logic [15:0] ss;
        logic sl;
        out_ready = 1'b0;
        wait (started);
        forever begin
            @(negedge clk);
            if (want_ready) begin
                check(in_ready === 1'b1, "R7", "in_ready after final output", int'(in_ready), 1);
                want_ready = 1'b0;
            end
            if (stalled) begin
                check(out_valid === 1'b1 && out_data === sd && out_scale === ss && out_last === sl,
                      "R10", "held beat data", int'(out_data), int'(sd));
                stalled = 1'b0;
            end
            out_ready = ((cyc % 5) != 2);
            if (out_valid && out_ready) begin
                if (exp_d.size() == 0) begin
                    check(1'b0, "R8", "unexpected output beat", int'(out_data), 0);
                end else begin
                    check(out_data === exp_d[0], exp_t[0], "out_data", int'(out_data), int'(exp_d[0]));
                    check(out_scale === exp_s[0], exp_st[0], "out_scale", int'(out_scale), int'(exp_s[0]));
                    check(out_last === exp_l[0], "R8", "out_last", int'(out_last), int'(exp_l[0]));
                    if (out_last) want_ready = 1'b1;
                    void'(exp_d.pop_front());
                    void'(exp_s.pop_front());
                    void'(exp_l.pop_front());
                    void'(exp_t.pop_front());
                    void'(exp_st.pop_front());
                end
            end else if (out_valid) begin
                stalled = 1'b1;
                sd = out_data;
                ss = out_scale;
                sl = out_last;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        in_last = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        started = 1'b1;

        // Table of tokens
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][15:0], VEC[i][16]);
        end

        // R9: a full-depth token with no last flag closes on its 64th sample
        for (int i = 0; i < 64; i++) begin
            send(16'(((i * 2731) % 6001) - 3000), 1'b0);
        end

        // R11: small token after a large one reports its own peak
        send(16'sd5, 1'b0);
        send(-16'sd5, 1'b1);

        // R6: lone most-negative sample
        send(16'h8000, 1'b1);

        while (exp_d.size() != 0 || !in_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule